// File: doc/BRIEF.md
# Looping Instruction Pump with Requeue Hatch

This block queues instructions for one port of a programmable interconnect node and presents them, one at a time, to the execution logic through an on-deck stage. Incoming words first land in an epilogue queue. A hatch moves them from there into a circular instruction queue. When an instruction that is marked for re-use leaves the on-deck stage while the outer loop counter is nonzero, a copy of it goes back into the circular queue. This is how a loop body is replayed. A tail word closes the hatch, so the next loop body waits behind it. The hatch opens again when a re-usable instruction finishes on deck while the outer loop counter is zero.

A torpedo token arriving on its own input is parked in a one-entry slot. The next interruptible move that passes its predicate is then cancelled instead of executed. The block signals the cancellation so that the counter logic outside can zero the outer count and set the inner count to one. The loop counters, the predicate evaluation and the move datapath all sit outside this block. They feed in a zero flag per counter and a predicate-true bit that is evaluated on the on-deck word.

Hatch states: `HATCH_OPEN` (words flow from the epilogue queue) and `HATCH_SEALED` (the epilogue queue is frozen). Transitions: OPEN to SEALED when a tail sits at the head of the epilogue queue. SEALED to OPEN when a re-usable instruction completes on deck with the outer count at zero. On-deck actions: `OD_EMPTY`, `OD_SKIP`, `OD_ABORT` and `OD_EXEC`.

Top module: `instr_pump`

## Requirements
- R1: Instruction fields are bits [IW-1:IW-2] for the class (00 move, 01 set, 10 shift, 11 tail), bit IW-3 for one-shot and bit IW-4 for interruptible (meaningful for moves only). One-shot words execute exactly once each, in arrival order.
- R2: A word with the one-shot bit clear is copied back into the circular queue when it leaves the on-deck stage, if `olc_zero` is low in that same cycle. The decision uses the count from before the word executes. No copy is made when `olc_zero` is high.
- R3: A tail word at the head of the epilogue queue closes an open hatch. It is removed without ever reaching the on-deck stage. Words behind it stay queued while the hatch is sealed.
- R4: The hatch reopens when a word with the one-shot bit clear completes on deck while `olc_zero` is high. Queued words then resume flowing.
- R5: An on-deck word with `pred_true` low is dropped. There is no exec, no abort, and any waiting torpedo stays parked.
- R6: When the on-deck word is an interruptible move with `pred_true` high and a torpedo parked, `abort_o` pulses for that cycle and the word does not execute. The torpedo slot is emptied. A non-interruptible move leaves the torpedo parked.
- R7: The torpedo slot holds one token. `torp_ready` is low while the slot is full, so a second token is held off until an abort empties the slot.
- R8: A move with `ilc_zero` high (and no abort) is skipped. Set and shift words execute regardless of `ilc_zero`.
- R9: While `exec_valid` is high and `exec_ready` is low, the on-deck word stays in place unchanged.
- R10: After reset, `in_ready` and `torp_ready` are high, the hatch is open, and `od_valid`, `exec_valid` and `abort_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Epilogue queue can accept |
| in_instr | input | IW | Instruction word |
| torp_valid | input | 1 | Torpedo token offered |
| torp_ready | output | 1 | Torpedo slot empty |
| pred_true | input | 1 | Predicate of the on-deck word holds |
| olc_zero | input | 1 | Outer loop count is zero |
| ilc_zero | input | 1 | Inner loop count is zero |
| exec_ready | input | 1 | Execution logic accepts the word |
| od_valid | output | 1 | On-deck stage occupied |
| od_instr | output | IW | On-deck word |
| exec_valid | output | 1 | On-deck word is to be executed |
| abort_o | output | 1 | On-deck move cancelled by a torpedo |

## Verification
One-shot sequences with a nonzero outer count show that only the re-use bit triggers replay. A two-word loop body followed by a tail and then a one-shot word, with the bench counter decrementing the outer count on each set, distinguishes three things: copying with a count from before or after execution, sealing versus leaking past the tail, and reopening on the final pass. Torpedo patterns mix predicate-false interruptible moves, plain moves and interruptible moves. They show that only the qualifying move consumes the token, and that a second token is held back. Zero-inner-count and stalled-execution runs separate skipped moves from executed non-moves, and a held word from one that moves on.

// File: rtl/pump_pkg.sv
package pump_pkg;
    typedef enum logic [1:0] {
        K_MOVE  = 2'b00,
        K_SET   = 2'b01,
        K_SHIFT = 2'b10,
        K_TAIL  = 2'b11
    } kind_e;

    typedef enum logic {
        HATCH_OPEN   = 1'b0,
        HATCH_SEALED = 1'b1
    } hatch_e;

    typedef enum logic [1:0] {
        OD_EMPTY,
        OD_SKIP,
        OD_ABORT,
        OD_EXEC
    } od_act_e;
endpackage

// File: rtl/pump_fifo.sv
module pump_fifo #(
    parameter int W     = 26,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_p, wr_p;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rd_p];

    always_ff @(posedge clk) begin
        if (push) mem[wr_p] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (push) wr_p <= bump(wr_p);
            if (pop)  rd_p <= bump(rd_p);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/pump_hatch.sv
module pump_hatch
    import pump_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic e_empty,
    input  logic e_head_tail,
    input  logic i_room,
    input  logic rq_push,
    input  logic unseal,
    output logic e_pop,
    output logic i_xfer
);
    hatch_e st, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= HATCH_OPEN;
        else        st <= nxt;
    end

    always_comb begin
        nxt    = st;
        e_pop  = 1'b0;
        i_xfer = 1'b0;
        unique case (st)
            HATCH_OPEN: begin
                if (!e_empty) begin
                    if (e_head_tail) begin
                        e_pop = 1'b1;
                        nxt   = HATCH_SEALED;
                    end else if (!rq_push && i_room) begin
                        e_pop  = 1'b1;
                        i_xfer = 1'b1;
                    end
                end
            end
            HATCH_SEALED: begin
                if (unseal) nxt = HATCH_OPEN;
            end
        endcase
    end
endmodule

// File: rtl/pump_ondeck.sv
module pump_ondeck
    import pump_pkg::*;
#(
    parameter int IW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_empty,
    input  logic [IW-1:0] i_head,
    input  logic          pred_true,
    input  logic          olc_zero,
    input  logic          ilc_zero,
    input  logic          exec_ready,
    input  logic          torp_valid,
    output logic          i_pop,
    output logic          rq_push,
    output logic          unseal,
    output logic          od_valid,
    output logic [IW-1:0] od_instr,
    output logic          exec_valid,
    output logic          abort_o,
    output logic          torp_ready
);
    localparam int OS_BIT  = IW - 3;
    localparam int INT_BIT = IW - 4;

    logic          od_vld, torp_full, done, is_move;
    logic [IW-1:0] od_q;
    od_act_e       act;

    assign is_move = (kind_e'(od_q[IW-1 -: 2]) == K_MOVE);

    always_comb begin
        if (!od_vld)                                   act = OD_EMPTY;
        else if (!pred_true)                           act = OD_SKIP;
        else if (is_move && od_q[INT_BIT] && torp_full) act = OD_ABORT;
        else if (is_move && ilc_zero)                  act = OD_SKIP;
        else                                           act = OD_EXEC;
    end

    always_comb begin
        done       = 1'b0;
        exec_valid = 1'b0;
        abort_o    = 1'b0;
        unique case (act)
            OD_EMPTY: ;
            OD_SKIP:  done = 1'b1;
            OD_ABORT: begin
                done    = 1'b1;
                abort_o = 1'b1;
            end
            OD_EXEC: begin
                exec_valid = 1'b1;
                done       = exec_ready;
            end
        endcase
    end

    assign rq_push    = done && !od_q[OS_BIT] && !olc_zero;
    assign unseal     = done && !od_q[OS_BIT] && olc_zero;
    assign i_pop      = (!od_vld || done) && !i_empty;
    assign od_valid   = od_vld;
    assign od_instr   = od_q;
    assign torp_ready = !torp_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            od_vld    <= 1'b0;
            od_q      <= '0;
            torp_full <= 1'b0;
        end else begin
            if (i_pop) begin
                od_vld <= 1'b1;
                od_q   <= i_head;
            end else if (done) begin
                od_vld <= 1'b0;
            end
            if (act == OD_ABORT)  torp_full <= 1'b0;
            else if (torp_valid)  torp_full <= 1'b1;
        end
    end
endmodule

// File: rtl/instr_pump.sv
module instr_pump
    import pump_pkg::*;
#(
    parameter int IW     = 26,
    parameter int IDEPTH = 8,
    parameter int EDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [IW-1:0] in_instr,
    input  logic          torp_valid,
    output logic          torp_ready,
    input  logic          pred_true,
    input  logic          olc_zero,
    input  logic          ilc_zero,
    input  logic          exec_ready,
    output logic          od_valid,
    output logic [IW-1:0] od_instr,
    output logic          exec_valid,
    output logic          abort_o
);
    logic          e_empty, e_full, e_pop;
    logic          i_empty, i_full, i_pop, i_push, i_xfer;
    logic          rq_push, unseal;
    logic [IW-1:0] e_head, i_head, i_din;

    assign in_ready = !e_full;
    assign i_push   = rq_push || i_xfer;
    assign i_din    = rq_push ? od_instr : e_head;

    pump_fifo #(.W(IW), .DEPTH(EDEPTH)) u_epi (
        .clk(clk), .rst_n(rst_n),
        .push(in_valid && !e_full), .din(in_instr),
        .pop(e_pop), .dout(e_head),
        .empty(e_empty), .full(e_full)
    );

    pump_hatch u_hatch (
        .clk(clk), .rst_n(rst_n),
        .e_empty(e_empty),
        .e_head_tail(kind_e'(e_head[IW-1 -: 2]) == K_TAIL),
        .i_room(!i_full || i_pop),
        .rq_push(rq_push), .unseal(unseal),
        .e_pop(e_pop), .i_xfer(i_xfer)
    );

    pump_fifo #(.W(IW), .DEPTH(IDEPTH)) u_loop (
        .clk(clk), .rst_n(rst_n),
        .push(i_push), .din(i_din),
        .pop(i_pop), .dout(i_head),
        .empty(i_empty), .full(i_full)
    );

    pump_ondeck #(.IW(IW)) u_od (
        .clk(clk), .rst_n(rst_n),
        .i_empty(i_empty), .i_head(i_head),
        .pred_true(pred_true), .olc_zero(olc_zero), .ilc_zero(ilc_zero),
        .exec_ready(exec_ready), .torp_valid(torp_valid),
        .i_pop(i_pop), .rq_push(rq_push), .unseal(unseal),
        .od_valid(od_valid), .od_instr(od_instr),
        .exec_valid(exec_valid), .abort_o(abort_o), .torp_ready(torp_ready)
    );
endmodule

// File: rtl/instr_pump_chk.sv
module instr_pump_chk #(
    parameter int IW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          torp_valid,
    input logic          torp_ready,
    input logic          pred_true,
    input logic          ilc_zero,
    input logic          exec_ready,
    input logic          od_valid,
    input logic [IW-1:0] od_instr,
    input logic          exec_valid,
    input logic          abort_o
);
    assert_tail_never_on_deck_R3: assert property (@(posedge clk) disable iff (!rst_n)
        od_valid |-> od_instr[IW-1 -: 2] != 2'b11);

    assert_pred_false_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        od_valid && !pred_true |-> !exec_valid && !abort_o);

    assert_abort_not_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> od_valid && !exec_valid);

    assert_abort_frees_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> torp_ready);

    assert_torp_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        torp_valid && torp_ready |=> !torp_ready);

    assert_torp_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !torp_ready && !abort_o |=> !torp_ready);

    assert_ilc_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        od_valid && pred_true && od_instr[IW-1 -: 2] == 2'b00 && ilc_zero && !abort_o
        |-> !exec_valid);

    assert_exec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid && !exec_ready |=> od_valid && $stable(od_instr));
endmodule

bind instr_pump instr_pump_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .torp_valid(torp_valid), .torp_ready(torp_ready),
    .pred_true(pred_true), .ilc_zero(ilc_zero), .exec_ready(exec_ready),
    .od_valid(od_valid), .od_instr(od_instr), .exec_valid(exec_valid),
    .abort_o(abort_o)
);

// File: tb/test_instr_pump.sv
module test_instr_pump;
    localparam int IW  = 26;
    localparam int TCK = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_instr = '0;
    logic          torp_valid = 1'b0;
    logic          ilc_zero = 1'b0;
    logic          exec_ready = 1'b1;
    logic          in_ready, torp_ready, pred_true, olc_zero;
    logic          od_valid, exec_valid, abort_o;
    logic [IW-1:0] od_instr;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the outer counter: set words decrement, abort zeroes
    int   olc_cnt = 0;
    int   olc_init = 0;
    logic olc_set = 1'b0;

    logic [IW-1:0] lg [64];
    int exec_n = 0;
    int abort_n = 0;

    always #(TCK/2) clk = ~clk;

    // bench predicate: payload bit 0 set means predicate false
    assign pred_true = !od_instr[0];
    assign olc_zero  = (olc_cnt == 0);

    instr_pump i_instr_pump (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .torp_valid(torp_valid), .torp_ready(torp_ready),
        .pred_true(pred_true), .olc_zero(olc_zero), .ilc_zero(ilc_zero),
        .exec_ready(exec_ready), .od_valid(od_valid), .od_instr(od_instr),
        .exec_valid(exec_valid), .abort_o(abort_o)
    );

    always @(posedge clk) begin
        if (olc_set) olc_cnt <= olc_init;
        else if (abort_o) olc_cnt <= 0;
        else if (exec_valid && exec_ready && od_instr[IW-1 -: 2] == 2'b01 && olc_cnt > 0)
            olc_cnt <= olc_cnt - 1;
    end

    always @(negedge clk) begin
        if (rst_n && exec_valid && exec_ready) begin
            if (exec_n < 64) lg[exec_n] = od_instr;
            exec_n = exec_n + 1;
        end
        if (rst_n && abort_o) abort_n = abort_n + 1;
    end

    function automatic logic [IW-1:0] mk(input logic [1:0] k, input logic os,
                                         input logic it, input logic [7:0] p);
        return {k, os, it, {(IW-12){1'b0}}, p};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [IW-1:0] w);
        in_valid = 1'b1;
        in_instr = w;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic set_olc(input int v);
        olc_init = v;
        olc_set  = 1'b1;
        @(posedge clk); #1;
        olc_set  = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(in_ready == 1'b1,   "R10 in_ready",   in_ready, 1);
        chk(torp_ready == 1'b1, "R10 torp_ready", torp_ready, 1);
        chk(!od_valid && !exec_valid && !abort_o, "R10 outputs idle",
            {od_valid, exec_valid, abort_o}, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_oneshot;
        int b;
        b = exec_n;
        set_olc(5);
        push(mk(2'b10, 1'b1, 1'b0, 8'h02));
        push(mk(2'b10, 1'b1, 1'b0, 8'h04));
        push(mk(2'b10, 1'b1, 1'b0, 8'h06));
        settle(30);
        chk(exec_n - b == 3, "R1 R2 one-shot count", exec_n - b, 3);
        for (int i = 0; i < 3; i++)
            chk(lg[b+i][7:0] == 8'(2*i + 2), "R1 order", lg[b+i][7:0], 2*i + 2);
    endtask

    task automatic t_loop;
        int b;
        logic [7:0] exp_seq [9];
        b = exec_n;
        for (int i = 0; i < 8; i++) exp_seq[i] = (i % 2 == 0) ? 8'h10 : 8'h20;
        exp_seq[8] = 8'h30;
        set_olc(3);
        push(mk(2'b00, 1'b0, 1'b0, 8'h10));
        push(mk(2'b01, 1'b0, 1'b0, 8'h20));
        push(mk(2'b11, 1'b0, 1'b0, 8'h00));
        push(mk(2'b10, 1'b1, 1'b0, 8'h30));
        settle(80);
        chk(exec_n - b == 9, "R2 R3 R4 loop exec count", exec_n - b, 9);
        for (int i = 0; i < 9; i++)
            chk(lg[b+i][7:0] == exp_seq[i], "R2 R3 R4 loop sequence", lg[b+i][7:0], exp_seq[i]);
        chk(olc_cnt == 0, "R2 counter drained", olc_cnt, 0);
    endtask

    task automatic t_pred;
        int b;
        b = exec_n;
        push(mk(2'b10, 1'b1, 1'b0, 8'h71));
        push(mk(2'b10, 1'b1, 1'b0, 8'h72));
        settle(20);
        chk(exec_n - b == 1, "R5 predicate false dropped", exec_n - b, 1);
        chk(lg[b][7:0] == 8'h72, "R5 survivor", lg[b][7:0], 8'h72);
    endtask

    task automatic t_ilc;
        int b;
        b = exec_n;
        ilc_zero = 1'b1;
        push(mk(2'b00, 1'b1, 1'b0, 8'h40));
        push(mk(2'b01, 1'b1, 1'b0, 8'h42));
        settle(20);
        chk(exec_n - b == 1, "R8 move skipped with zero ilc", exec_n - b, 1);
        chk(lg[b][7:0] == 8'h42, "R8 set still executes", lg[b][7:0], 8'h42);
        ilc_zero = 1'b0;
    endtask

    task automatic t_torp;
        int b, a;
        b = exec_n;
        a = abort_n;
        torp_valid = 1'b1;
        @(posedge clk); #1;
        torp_valid = 1'b0;
        @(negedge clk);
        chk(torp_ready == 1'b0, "R7 slot full", torp_ready, 0);
        @(posedge clk); #1;
        torp_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(torp_ready == 1'b0, "R7 second token held off", torp_ready, 0);
        end
        @(posedge clk); #1;
        torp_valid = 1'b0;
        push(mk(2'b00, 1'b1, 1'b1, 8'h51));
        settle(15);
        chk(abort_n == a && exec_n == b && !torp_ready, "R5 false predicate keeps torpedo",
            {abort_n - a, exec_n - b, torp_ready}, 0);
        push(mk(2'b00, 1'b1, 1'b0, 8'h50));
        settle(15);
        chk(exec_n - b == 1 && !torp_ready, "R6 plain move keeps torpedo",
            {exec_n - b, torp_ready}, 2);
        push(mk(2'b00, 1'b1, 1'b1, 8'h52));
        settle(15);
        chk(abort_n - a == 1, "R6 abort pulse", abort_n - a, 1);
        chk(exec_n - b == 1, "R6 aborted move not executed", exec_n - b, 1);
        chk(torp_ready == 1'b1, "R6 R7 slot emptied", torp_ready, 1);
    endtask

    task automatic t_stall;
        int b;
        logic [IW-1:0] w;
        b = exec_n;
        w = mk(2'b10, 1'b1, 1'b0, 8'h60);
        exec_ready = 1'b0;
        push(w);
        settle(10);
        @(negedge clk);
        chk(exec_valid && od_instr == w, "R9 stalled word presented", od_instr, w);
        settle(5);
        @(negedge clk);
        chk(exec_valid && od_instr == w && exec_n == b, "R9 word held", od_instr, w);
        @(posedge clk); #1;
        exec_ready = 1'b1;
        settle(5);
        chk(exec_n - b == 1, "R9 released once", exec_n - b, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_oneshot();
        t_loop();
        t_pred();
        t_ilc();
        t_torp();
        t_stall();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule